// File: doc/BRIEF.md
# Mirror-Order Pointer Address Generator

This block computes the byte address for an indirect data write and the new value of the pointer register used for that write. Its purpose is walking a buffer in bit-reversed element order, which is how FFT data is reordered. A control register holds an enable flag and a 15-bit pivot. Software sets the pivot to half the buffer length, counted in data elements.

While the flag is set, the pointer moves by mirror addition. This is a sum in which carries travel from high bits toward low bits. The pivot is first scaled to bytes according to the data width. The ordinary register-indirect step is dropped, and the low address bits that must be zero for the data width are cleared. While the flag is clear, the pointer steps by the element size. It can optionally wrap inside a modulo window. Bit reversal overrides that window when both apply.

Each request gives the pointer, the data width and whether the pointer is modified before or after use. One clock later the block returns the effective address, the updated pointer and a flag telling whether bit reversal was applied. A write to the control register is staged, so it does not affect a request sampled in the following cycle.

Top module: `brev_agu`

## Requirements
- R1: After reset, all outputs are zero, and the control register is zero (bit reversal disabled, pivot 0).
- R2: A control write captured at clock edge e takes effect only for requests sampled at edge e+2 or later. Bit 15 is the enable flag and bits 14:0 are the pivot. Requests at edges e and e+1 use the previous setting.
- R3: When enabled, the new pointer is the mirror sum (carry flowing toward bit 0, carry out of bit 0 dropped) of the pointer and the pivot shifted left by 1 (16-bit data, `wideData`=0) or by 2 (32-bit data, `wideData`=1). Address bit 0 (16-bit) or bits 1:0 (32-bit) of the result are then cleared.
- R4: With pivot 2^(k-1), a 16-bit buffer aligned to 2^(k+1) bytes or a 32-bit buffer aligned to 2^(k+2) bytes is visited in element order bitrev_k(i) by post-modify requests, and the pointer is back at the base after 2^k updates.
- R5: When enabled, the normal +2/+4 step is not applied.
- R6: With `preModify`=1, the effective address equals the new pointer.
- R7: With `preModify`=0, the effective address is the incoming pointer. When bit reversal applies, its low bits are cleared as in R3.
- R8: When disabled and modulo is off, the new pointer is the incoming pointer plus 2 (16-bit) or plus 4 (32-bit).
- R9: When disabled and `modEn`=1, a pointer at or above `modEnd` is replaced by `modStart`. Otherwise it steps as in R8.
- R10: When enabled and `modEn`=1, bit reversal wins and `brevUsed` is 1.
- R11: `respValid` follows `reqValid` by one cycle. Outputs hold while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 16 | Control value: bit 15 enable, bits 14:0 pivot |
| reqValid | input | 1 | Address request present |
| ptrIn | input | AW | Current pointer (byte address) |
| wideData | input | 1 | 0 = 16-bit data, 1 = 32-bit data |
| preModify | input | 1 | 1 = modify before use, 0 = after use |
| modEn | input | 1 | Modulo window enabled on this pointer |
| modStart | input | AW | First address of the modulo window |
| modEnd | input | AW | Last element address of the modulo window |
| respValid | output | 1 | Result valid |
| effAddr | output | AW | Effective byte address |
| ptrNext | output | AW | Updated pointer |
| brevUsed | output | 1 | Bit-reversed update was applied |

## Verification
Two collisions are provoked on purpose. The first is a control-register write arriving in the same cycle as a request, followed by a request in the very next cycle. The reference model in the bench stages the write for two edges, so any early or late take-up of the new setting shows up as a wrong pointer. The second is a request with modulo enabled while bit reversal is enabled. Its pointer is placed inside the window so that wrapping and mirror addition give different answers, and the result is judged against the mirror sum and the `brevUsed` flag.

// File: rtl/brev_pkg.sv
package brev_pkg;
  // Strobes handed from control to datapath for one request
  typedef struct packed {
    logic capture;   // request present this cycle
    logic useBrev;   // apply mirror addition
    logic useMod;    // apply modulo wrap to the plain step
    logic wide;      // 32-bit elements
    logic pre;       // pre-modify
  } agu_strobe_t;
endpackage

// File: rtl/brev_ctrl.sv
module brev_ctrl
  import brev_pkg::*;
#(
  parameter int PIV_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [PIV_W:0]     cfgWrData,
  input  logic               reqValid,
  input  logic               wideData,
  input  logic               preModify,
  input  logic               modEn,
  output agu_strobe_t        strobe,
  output logic [PIV_W-1:0]   pivot
);
  localparam int CFG_W  = PIV_W + 1;
  localparam int EN_BIT = PIV_W;

  logic [CFG_W-1:0] stagedCfg;
  logic [CFG_W-1:0] activeCfg;
  logic             enFlag;

  // Two-stage path: a write lands in the staging copy, then the live copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedCfg <= '0;
      activeCfg <= '0;
    end else begin
      activeCfg <= stagedCfg;
      if (cfgWrEn) stagedCfg <= cfgWrData;
    end
  end

  assign enFlag = activeCfg[EN_BIT];
  assign pivot  = activeCfg[PIV_W-1:0];

  always_comb begin
    strobe.capture = reqValid;
    strobe.useBrev = reqValid & enFlag;
    strobe.useMod  = reqValid & modEn & ~enFlag;
    strobe.wide    = wideData;
    strobe.pre     = preModify;
  end
endmodule

// File: rtl/brev_datapath.sv
module brev_datapath
  import brev_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PIV_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  agu_strobe_t      strobe,
  input  logic [PIV_W-1:0] pivot,
  input  logic [AW-1:0]    ptrIn,
  input  logic [AW-1:0]    modStart,
  input  logic [AW-1:0]    modEnd,
  output logic             respValid,
  output logic [AW-1:0]    effAddr,
  output logic [AW-1:0]    ptrNext,
  output logic             brevUsed
);
  logic [AW-1:0] pivBytes;
  logic [AW-1:0] alignMask;
  logic [AW-1:0] ptrRev, pivRev, sumRev, mirSum;
  logic [AW-1:0] stepSum, plainNext, brevNext, nextPtr, addrOut;

  // Pivot scaled from elements to bytes
  assign pivBytes  = strobe.wide ? AW'({pivot, 2'b00}) : AW'({pivot, 1'b0});
  assign alignMask = strobe.wide ? {{(AW-2){1'b1}}, 2'b00} : {{(AW-1){1'b1}}, 1'b0};

  // Mirror addition: reverse operands, add, reverse back
  for (genvar b = 0; b < AW; b++) begin : g_mirror
    assign ptrRev[b] = ptrIn[AW-1-b];
    assign pivRev[b] = pivBytes[AW-1-b];
    assign mirSum[b] = sumRev[AW-1-b];
  end
  assign sumRev   = ptrRev + pivRev;
  assign brevNext = mirSum & alignMask;

  // Plain step with optional window wrap
  assign stepSum   = ptrIn + (strobe.wide ? AW'(4) : AW'(2));
  assign plainNext = (strobe.useMod && (ptrIn >= modEnd)) ? modStart : stepSum;

  assign nextPtr = strobe.useBrev ? brevNext : plainNext;
  assign addrOut = strobe.pre     ? nextPtr
                 : (strobe.useBrev ? (ptrIn & alignMask) : ptrIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      effAddr   <= '0;
      ptrNext   <= '0;
      brevUsed  <= 1'b0;
    end else begin
      respValid <= strobe.capture;
      if (strobe.capture) begin
        effAddr  <= addrOut;
        ptrNext  <= nextPtr;
        brevUsed <= strobe.useBrev;
      end
    end
  end
endmodule

// File: rtl/brev_agu.sv
module brev_agu
  import brev_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PIV_W = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [PIV_W:0]  cfgWrData,
  input  logic            reqValid,
  input  logic [AW-1:0]   ptrIn,
  input  logic            wideData,
  input  logic            preModify,
  input  logic            modEn,
  input  logic [AW-1:0]   modStart,
  input  logic [AW-1:0]   modEnd,
  output logic            respValid,
  output logic [AW-1:0]   effAddr,
  output logic [AW-1:0]   ptrNext,
  output logic            brevUsed
);
  agu_strobe_t      strobe;
  logic [PIV_W-1:0] pivot;

  brev_ctrl #(.PIV_W(PIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .wideData(wideData), .preModify(preModify),
    .modEn(modEn), .strobe(strobe), .pivot(pivot)
  );

  brev_datapath #(.AW(AW), .PIV_W(PIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pivot(pivot), .ptrIn(ptrIn),
    .modStart(modStart), .modEnd(modEnd), .respValid(respValid),
    .effAddr(effAddr), .ptrNext(ptrNext), .brevUsed(brevUsed)
  );
endmodule

// File: rtl/brev_agu_chk.sv
module brev_agu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [AW-1:0] ptrIn,
  input logic          wideData,
  input logic          preModify,
  input logic          modEn,
  input logic          respValid,
  input logic [AW-1:0] effAddr,
  input logic [AW-1:0] ptrNext,
  input logic          brevUsed
);
  logic armed;
  always_ff @(posedge clk) armed <= rstN;

  // R11
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (respValid == $past(reqValid)));

  // R6
  pre_addr_is_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && respValid && $past(preModify)) |-> (effAddr == ptrNext));

  // R7
  post_addr_is_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && respValid && !$past(preModify) && !brevUsed) |-> (effAddr == $past(ptrIn)));

  // R3
  brev_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && respValid && brevUsed) |->
      (!ptrNext[0] && !effAddr[0] && (!$past(wideData) || (ptrNext[1:0] == 2'b00))));

  // R8
  plain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && respValid && !brevUsed && !$past(modEn)) |->
      (ptrNext == $past(ptrIn) + ($past(wideData) ? AW'(4) : AW'(2))));
endmodule

bind brev_agu brev_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .ptrIn(ptrIn),
  .wideData(wideData), .preModify(preModify), .modEn(modEn),
  .respValid(respValid), .effAddr(effAddr), .ptrNext(ptrNext),
  .brevUsed(brevUsed)
);

// File: tb/test_brev_agu.sv
`timescale 1ns/1ps
module test_brev_agu;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWrEn;
  logic [15:0]   cfgWrData;
  logic          reqValid;
  logic [AW-1:0] ptrIn;
  logic          wideData, preModify, modEn;
  logic [AW-1:0] modStart, modEnd;
  logic          respValid, brevUsed;
  logic [AW-1:0] effAddr, ptrNext;

  int vectors = 0;
  int misses  = 0;

  // reference model state
  logic [15:0]   stagedM = '0, activeM = '0;
  logic          expValid = 0, expBrev = 0;
  logic [AW-1:0] expAddr = '0, expNext = '0;

  always #2 clk = ~clk;

  brev_agu i_brev_agu (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .ptrIn(ptrIn), .wideData(wideData),
    .preModify(preModify), .modEn(modEn), .modStart(modStart), .modEnd(modEnd),
    .respValid(respValid), .effAddr(effAddr), .ptrNext(ptrNext), .brevUsed(brevUsed)
  );

  // bit-serial sum, carries running from high bit to low bit
  function automatic logic [AW-1:0] mirrorAdd(logic [AW-1:0] a, logic [AW-1:0] b);
    logic [AW-1:0] r;
    int c = 0;
    for (int i = AW-1; i >= 0; i--) begin
      int s;
      s = int'(a[i]) + int'(b[i]) + c;
      r[i] = s[0];
      c = s / 2;
    end
    return r;
  endfunction

  function automatic int revIdx(int v, int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (v[i]) r = r | (1 << (k-1-i));
    return r;
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    misses++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic issue(input logic v, input logic [AW-1:0] p, input logic w,
                       input logic pre, input logic m, input logic cw,
                       input logic [15:0] cd, input string tag);
    logic [AW-1:0] clr, nx;
    reqValid = v; ptrIn = p; wideData = w; preModify = pre; modEn = m;
    cfgWrEn = cw; cfgWrData = cd;
    @(posedge clk);
    if (v) begin
      clr = w ? 16'hFFFC : 16'hFFFE;
      if (activeM[15]) begin
        nx = mirrorAdd(p, w ? AW'({activeM[14:0], 2'b00}) : AW'({activeM[14:0], 1'b0})) & clr;
        expAddr = pre ? nx : (p & clr);
        expBrev = 1;
      end else begin
        if (m && p >= modEnd) nx = modStart;
        else nx = p + (w ? 16'd4 : 16'd2);
        expAddr = pre ? nx : p;
        expBrev = 0;
      end
      expNext = nx;
    end
    expValid = v;
    activeM = stagedM;
    if (cw) stagedM = cd;
    @(negedge clk);
    vectors++;
    if (respValid !== expValid) fail(tag, "respValid", respValid, expValid);
    if (effAddr !== expAddr)    fail(tag, "effAddr", effAddr, expAddr);
    if (ptrNext !== expNext)    fail(tag, "ptrNext", ptrNext, expNext);
    if (brevUsed !== expBrev)   fail(tag, "brevUsed", brevUsed, expBrev);
    reqValid = 0; cfgWrEn = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) issue(0, 16'h0, 0, 0, 0, 0, 16'h0, tag);
  endtask

  // R4: walk a 2^k element buffer and compare with index reversal
  task automatic walk(int k, logic w, logic [AW-1:0] base);
    logic [AW-1:0] p = base;
    int sz = w ? 4 : 2;
    issue(0, 16'h0, 0, 0, 0, 1, 16'h8000 | 16'(1 << (k-1)), "R4");
    idle(2, "R4");
    for (int i = 0; i < (1 << k); i++) begin
      issue(1, p, w, 0, 0, 0, 16'h0, "R4");
      if (effAddr !== base + AW'(revIdx(i, k) * sz)) begin
        fail("R4", "order", effAddr, base + AW'(revIdx(i, k) * sz));
      end
      vectors++;
      p = ptrNext;
    end
    vectors++;
    if (p !== base) fail("R4", "return to base", p, base);
  endtask

  initial begin
    #800000;
    misses++;
    $display("FAIL watchdog: actual %h expected %h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgWrData = '0; reqValid = 0; ptrIn = '0;
    wideData = 0; preModify = 0; modEn = 0; modStart = 16'h0100; modEnd = 16'h0106;
    repeat (3) @(negedge clk);
    rstN = 1;
    vectors++;
    if (respValid !== 0 || effAddr !== 0 || ptrNext !== 0 || brevUsed !== 0)
      fail("R1", "reset outputs", {respValid, effAddr}, 0);
    // R1: control register starts disabled
    issue(1, 16'h1000, 0, 0, 0, 0, 16'h0, "R1");
    // R8 / R7 / R6: plain steps
    issue(1, 16'h1000, 0, 0, 0, 0, 16'h0, "R8");
    issue(1, 16'h1000, 1, 1, 0, 0, 16'h0, "R6");
    issue(1, 16'h2000, 1, 0, 0, 0, 16'h0, "R7");
    // R11: outputs hold with no request
    idle(2, "R11");
    // R9: modulo wrap and non-wrap
    issue(1, 16'h0106, 0, 0, 1, 0, 16'h0, "R9");
    issue(1, 16'h0102, 0, 1, 1, 0, 16'h0, "R9");
    // R2: write with a request in the same cycle, then next cycle, then after
    issue(1, 16'h0300, 0, 0, 0, 1, 16'h8008, "R2");
    issue(1, 16'h0300, 0, 0, 0, 0, 16'h0, "R2");
    issue(1, 16'h0300, 0, 0, 0, 0, 16'h0, "R2");
    // R10: brev beats the window; R5: no plain step
    issue(1, 16'h0102, 0, 0, 1, 0, 16'h0, "R10");
    issue(1, 16'h0310, 1, 1, 0, 0, 16'h0, "R5");
    // R3: misaligned pointer gets low bits cleared
    issue(1, 16'h2003, 1, 1, 0, 0, 16'h0, "R3");
    issue(1, 16'h2003, 0, 0, 0, 0, 16'h0, "R3");
    // R4: buffer sizes 8, 16, 1024 in both widths
    walk(3, 0, 16'h0040);
    walk(3, 1, 16'h0080);
    walk(4, 0, 16'h0100);
    walk(4, 1, 16'h0200);
    walk(10, 0, 16'h2000);
    walk(10, 1, 16'h4000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule